// File: doc/BRIEF.md
# SPI Word Buffer and Interrupt Unit

This unit is the processor-facing half of a serial peripheral controller. It buffers outgoing and incoming 32-bit words in two eight-entry queues. Software fills the transmit queue and drains the receive queue through a small register port. The shift engine takes words from the transmit queue and delivers words into the receive queue. A single interrupt line tells software when the queues need attention or when a transfer has ended.

The unit keeps a packed count register for both queues and one shared threshold register. From the counts it derives two service requests, one for each direction. It flags a transmit underflow when the engine asks for a word that is not there, and a receive overflow when a word arrives with no room for it. Each cause is held in a status bit that software clears by writing a one to it. A mask selects which held causes drive the interrupt. The register port is combinational on reads: `reg_rdata_o` is valid in the cycle the request is presented, and any queue pop or register update takes effect at the next rising clock edge.

Top module: `spi_buf_irq`

## Requirements
- R1: After reset, the held status bits, the interrupt mask and both queue counts are zero, the threshold register reads 0x80 and `irq_o` is low.
- R2: A write to word address 4 pushes a word into the transmit queue. Word address 3 reads the transmit count in bits [7:4] and the receive count in bits [3:0]. Each `eng_tx_req_i` pulse consumes the word shown on `eng_tx_data_o`, and words leave in the order they were written.
- R3: Each `eng_rx_valid_i` cycle stores `eng_rx_data_i`. A read of word address 5 returns the oldest stored word and removes it. A read of address 5 while the receive queue is empty returns zero and leaves both counts unchanged.
- R4: A write to address 4 while the transmit queue holds 8 words is discarded: the count stays 8 and the stored words are unchanged.
- R5: Word address 0 is the status register. Its bit 0 follows `eng_busy_i` in the same cycle, and writes do not change it.
- R6: Status bit 1 sets on the edge that samples `eng_done_i` high and stays set until software writes a one to it. Writing zero leaves it set. If a set and a clear come in the same cycle, the bit stays set. Bits 1 to 5 all follow this rule.
- R7: Word address 2 holds the transmit level in bits [3:0] and the receive level in bits [7:4]. Status bit 2 sets while the transmit count is at or below the transmit level. Status bit 3 sets while the receive count is at or above the receive level.
- R8: Status bit 4 sets when `eng_tx_req_i` is high while the transmit queue is empty. No word is consumed.
- R9: Status bit 5 sets when `eng_rx_valid_i` is high while the receive queue holds 8 words. The arriving word is dropped and the stored words are unchanged.
- R10: Word address 1 is the interrupt mask. Bit 0 enables status bit 1, bit 1 enables bit 2, bit 2 enables bit 3, bit 3 enables bit 4 and bit 4 enables bit 5. `irq_o` is the OR of the enabled held bits, with no extra cycle of delay.
- R11: The mask register keeps only 5 bits and the threshold register only 8 bits. All other bits of these registers, and any word address above 5, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| eng_tx_req_i | input | 1 | Engine takes one transmit word |
| eng_tx_valid_o | output | 1 | Transmit queue not empty |
| eng_tx_data_o | output | 32 | Oldest transmit word |
| eng_rx_valid_i | input | 1 | Engine delivers one received word |
| eng_rx_data_i | input | 32 | Received word |
| eng_busy_i | input | 1 | Engine has a transfer in progress |
| eng_done_i | input | 1 | Transfer-complete pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Register reads and `eng_tx_data_o` settle in the same cycle. Queue counts change one edge after a push or pop. A held status bit, and therefore `irq_o`, changes one edge after its cause is sampled. Threshold bits need one more edge after the count moves, because they compare against the registered count. The bench drives every input at the falling edge and samples outputs 1 ns after it, so each read happens before the edge that would pop or update anything. Checks on threshold bits wait one idle cycle after the last count change.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  typedef enum logic [3:0] {
    A_STAT = 4'd0,
    A_IEN  = 4'd1,
    A_THR  = 4'd2,
    A_CNT  = 4'd3,
    A_TXD  = 4'd4,
    A_RXD  = 4'd5
  } reg_addr_e;

  localparam int ST_PEND = 0;
  localparam int ST_DONE = 1;
  localparam int ST_TXTH = 2;
  localparam int ST_RXTH = 3;
  localparam int ST_TXUF = 4;
  localparam int ST_RXOF = 5;
  localparam int ST_W    = 6;
  localparam int IE_W    = ST_W - 1;
  localparam int FLD_W   = 4;
  localparam logic [2*FLD_W-1:0] THR_RST = 8'h80;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = empty_o ? '0 : mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
  p_full_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o);
  p_empty_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o);
endmodule

// File: rtl/stat_irq.sv
module stat_irq #(
  parameter int ST_W = 6,
  localparam int EW  = ST_W - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pend_i,
  input  logic [EW-1:0]   set_i,
  input  logic [EW-1:0]   clr_i,
  input  logic [EW-1:0]   ien_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic [EW-1:0] held_q;

  for (genvar k = 0; k < EW; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       held_q[k] <= 1'b0;
      else if (set_i[k]) held_q[k] <= 1'b1;  // set wins over clear
      else if (clr_i[k]) held_q[k] <= 1'b0;
    end

    p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> stat_o[k+1]);
    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[k+1] && !clr_i[k] |=> stat_o[k+1]);
  end

  assign stat_o = {held_q, pend_i};
  assign irq_o  = |(held_q & ien_i);

  p_irq_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[ST_W-1:1] == '0) |-> !irq_o);
endmodule

// File: rtl/spi_buf_irq.sv
module spi_buf_irq
  import spi_buf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          eng_tx_req_i,
  output logic          eng_tx_valid_o,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_rx_valid_i,
  input  logic [DW-1:0] eng_rx_data_i,
  input  logic          eng_busy_i,
  input  logic          eng_done_i,
  output logic          irq_o
);
  logic wr, rd;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [FLD_W-1:0] tx_cnt_f, rx_cnt_f;
  logic [DW-1:0] rx_head;
  logic [IE_W-1:0] ien_q, set_v, clr_v;
  logic [2*FLD_W-1:0] thr_q;
  logic [ST_W-1:0] stat;
  logic unused_wdata;

  assign wr = reg_req_i && reg_we_i;
  assign rd = reg_req_i && !reg_we_i;
  assign unused_wdata = ^{reg_wdata_i[DW-1:2*FLD_W], reg_wdata_i[0]};

  word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .push_i (wr && reg_addr_i == AW'(A_TXD)),
    .data_i (reg_wdata_i),
    .pop_i  (eng_tx_req_i),
    .data_o (eng_tx_data_o),
    .cnt_o  (tx_cnt),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .push_i (eng_rx_valid_i),
    .data_i (eng_rx_data_i),
    .pop_i  (rd && reg_addr_i == AW'(A_RXD)),
    .data_o (rx_head),
    .cnt_o  (rx_cnt),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  assign eng_tx_valid_o = !tx_empty;
  assign tx_cnt_f = FLD_W'(tx_cnt);
  assign rx_cnt_f = FLD_W'(rx_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      thr_q <= THR_RST;
    end else if (wr) begin
      if (reg_addr_i == AW'(A_IEN)) ien_q <= reg_wdata_i[IE_W-1:0];
      if (reg_addr_i == AW'(A_THR)) thr_q <= reg_wdata_i[2*FLD_W-1:0];
    end
  end

  // cause index k maps to status bit k+1
  always_comb begin
    set_v = '0;
    set_v[ST_DONE-1] = eng_done_i;
    set_v[ST_TXTH-1] = tx_cnt_f <= thr_q[FLD_W-1:0];
    set_v[ST_RXTH-1] = rx_cnt_f >= thr_q[2*FLD_W-1:FLD_W];
    set_v[ST_TXUF-1] = eng_tx_req_i && tx_empty;
    set_v[ST_RXOF-1] = eng_rx_valid_i && rx_full;
  end

  assign clr_v = (wr && reg_addr_i == AW'(A_STAT)) ? reg_wdata_i[ST_W-1:1] : '0;

  stat_irq #(.ST_W(ST_W)) u_stat (
    .clk_i, .rst_ni,
    .pend_i(eng_busy_i),
    .set_i (set_v),
    .clr_i (clr_v),
    .ien_i (ien_q),
    .stat_o(stat),
    .irq_o (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(A_STAT): reg_rdata_o = DW'(stat);
      AW'(A_IEN):  reg_rdata_o = DW'(ien_q);
      AW'(A_THR):  reg_rdata_o = DW'(thr_q);
      AW'(A_CNT):  reg_rdata_o = DW'({tx_cnt_f, rx_cnt_f});
      AW'(A_RXD):  reg_rdata_o = rx_head;
      default:     reg_rdata_o = '0;
    endcase
  end

  p_uf_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_tx_req_i && tx_empty |=> stat[ST_TXUF]);
  p_of_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rx_valid_i && rx_full |=> stat[ST_RXOF]);
  p_of_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rx_valid_i && rx_full && !(rd && reg_addr_i == AW'(A_RXD)) |=> rx_full);
  p_tx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_empty && !eng_tx_req_i |=> !tx_empty);
endmodule

// File: tb/spi_buf_irq_tb_top.sv
`timescale 1ns/1ps
module spi_buf_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tx_req = 0, tx_valid;
  logic [31:0] tx_data;
  logic rx_valid = 0;
  logic [31:0] rx_data = '0;
  logic busy = 0, done = 0, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_buf_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eng_tx_req_i(tx_req), .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data),
    .eng_rx_valid_i(rx_valid), .eng_rx_data_i(rx_data),
    .eng_busy_i(busy), .eng_done_i(done), .irq_o(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] m;
    logic [3:0]  rq;
  } vec_t;
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd0, 32'h0,        32'h3B,       4'd1},  // R1 status
    '{1'b1, 4'd1, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask
    '{1'b1, 4'd2, 32'h80,       32'hFFFFFFFF, 4'd1},  // R1 threshold
    '{1'b1, 4'd3, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 counts
    '{1'b0, 4'd4, 32'h11111111, 32'h0,        4'd2},  // R2 push
    '{1'b0, 4'd4, 32'h22222222, 32'h0,        4'd2},
    '{1'b0, 4'd4, 32'h33333333, 32'h0,        4'd2},
    '{1'b1, 4'd3, 32'h30,       32'hFFFFFFFF, 4'd2},  // R2 tx count 3
    '{1'b0, 4'd1, 32'hFFFFFFFF, 32'h0,        4'd11},
    '{1'b1, 4'd1, 32'h1F,       32'hFFFFFFFF, 4'd11}, // R11 five bits
    '{1'b0, 4'd1, 32'h0,        32'h0,        4'd11},
    '{1'b0, 4'd2, 32'hFFFFFF52, 32'h0,        4'd7},
    '{1'b1, 4'd2, 32'h52,       32'hFFFFFFFF, 4'd7},  // R7, R11 eight bits
    '{1'b1, 4'd5, 32'h0,        32'hFFFFFFFF, 4'd3},  // R3 empty pop
    '{1'b1, 4'd3, 32'h30,       32'hFFFFFFFF, 4'd3},  // R3 counts intact
    '{1'b1, 4'd7, 32'h0,        32'hFFFFFFFF, 4'd11}  // R11 unmapped
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic rd_chk(input string rq, input logic [3:0] a, input logic [31:0] m,
                        input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(rq, v & m, exp & m);
  endtask

  task automatic eng_pop();
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: state held in reset
    idle(2);
    req = 1; addr = 4'd0; #1 chk("R1", rdata, 32'h0);
    addr = 4'd2; #1 chk("R1", rdata, 32'h80);
    addr = 4'd3; #1 chk("R1", rdata, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    req = 0;
    @(negedge clk); rst_n = 1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) rd_chk($sformatf("R%0d", VECS[i].rq), VECS[i].a, VECS[i].m, VECS[i].d);
      else bus_wr(VECS[i].a, VECS[i].d);
    end

    // R2: engine consumes in order
    #1 chk("R2", tx_data, 32'h11111111);
    eng_pop(); #1 chk("R2", tx_data, 32'h22222222);
    eng_pop(); #1 chk("R2", tx_data, 32'h33333333);
    eng_pop(); #1 chk("R2", {31'b0, tx_valid}, 32'h0);
    rd_chk("R2", 4'd3, 32'hFF, 32'h00);

    // R8: underflow, then R6 clear
    bus_wr(4'd0, 32'h3E);
    rd_chk("R8", 4'd0, 32'h10, 32'h00);
    eng_pop();
    rd_chk("R8", 4'd0, 32'h10, 32'h10);
    rd_chk("R8", 4'd3, 32'hFF, 32'h00);
    bus_wr(4'd0, 32'h10);
    rd_chk("R6", 4'd0, 32'h10, 32'h00);

    // R4: overfill tx
    for (int i = 0; i < 10; i++) bus_wr(4'd4, 32'hA0 + i);
    rd_chk("R4", 4'd3, 32'hF0, 32'h80);
    bus_wr(4'd0, 32'h04);
    idle(1);
    rd_chk("R7", 4'd0, 32'h04, 32'h00);  // count 8 above level 2
    for (int i = 0; i < 8; i++) begin
      #1 chk("R4", tx_data, 32'hA0 + i);
      eng_pop();
    end
    #1 chk("R4", {31'b0, tx_valid}, 32'h0);
    idle(1);
    rd_chk("R7", 4'd0, 32'h04, 32'h04);  // count 0 at/below level 2

    // R7 receive threshold, R9 overflow, R3 order
    bus_wr(4'd0, 32'h08);
    rd_chk("R7", 4'd0, 32'h08, 32'h00);
    for (int i = 0; i < 5; i++) eng_push(32'hB0 + i);
    idle(1);
    rd_chk("R7", 4'd0, 32'h08, 32'h08);
    for (int i = 5; i < 8; i++) eng_push(32'hB0 + i);
    rd_chk("R9", 4'd0, 32'h20, 32'h00);
    eng_push(32'hDEAD);
    rd_chk("R9", 4'd0, 32'h20, 32'h20);
    rd_chk("R9", 4'd3, 32'h0F, 32'h08);
    for (int i = 0; i < 8; i++) rd_chk("R3", 4'd5, 32'hFFFFFFFF, 32'hB0 + i);
    rd_chk("R3", 4'd5, 32'hFFFFFFFF, 32'h0);
    rd_chk("R3", 4'd3, 32'hFF, 32'h00);

    // R6 done bit and R10 interrupt
    bus_wr(4'd0, 32'h3E);
    bus_wr(4'd1, 32'h01);
    #1 chk("R10", {31'b0, irq}, 32'h0);
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    #1 chk("R10", {31'b0, irq}, 32'h1);
    rd_chk("R6", 4'd0, 32'h02, 32'h02);
    bus_wr(4'd0, 32'h00);
    rd_chk("R6", 4'd0, 32'h02, 32'h02);
    @(negedge clk); done = 1; req = 1; we = 1; addr = 4'd0; wdata = 32'h02;
    @(negedge clk); done = 0; req = 0; we = 0;
    rd_chk("R6", 4'd0, 32'h02, 32'h02);
    bus_wr(4'd0, 32'h02);
    rd_chk("R6", 4'd0, 32'h02, 32'h00);
    #1 chk("R10", {31'b0, irq}, 32'h0);
    bus_wr(4'd1, 32'h08);
    #1 chk("R10", {31'b0, irq}, 32'h0);
    eng_pop();
    #1 chk("R10", {31'b0, irq}, 32'h1);
    bus_wr(4'd1, 32'h00);
    #1 chk("R10", {31'b0, irq}, 32'h0);

    // R5 busy mirror
    @(negedge clk); busy = 1;
    rd_chk("R5", 4'd0, 32'h01, 32'h01);
    bus_wr(4'd0, 32'h01);
    rd_chk("R5", 4'd0, 32'h01, 32'h01);
    @(negedge clk); busy = 0;
    rd_chk("R5", 4'd0, 32'h01, 32'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule